// File: doc/BRIEF.md
# Timer Gate Control Unit

This block decides, clock by clock, whether a 16-bit event counter may advance. It picks one of four gate sources: a synchronized external pin, the wrap event of an 8-bit timer, or one of two period-match events. It then applies a polarity choice and passes the result through two optional shaping stages.

The first shaping stage is a toggle flip-flop. With it enabled, the counter runs over a whole period of the source rather than over one level. The second is a single-pulse capture stage. Software arms it with a go/done flag, and it lets exactly one gate window through before it disarms itself. The two stages can be chained so that exactly one full source period is measured.

A master enable chooses between free counting on every clock and gated counting. A status output always reports the shaped gate level, whatever the master enable is set to. The counter is part of the block so that the gate's effect can be seen at the ports.

Top module: `tmr_gate_unit`

## Requirements
- R1: `src_sel` picks the gate source: 0 = synchronized `gate_pin`, 1 = `ovf8_evt`, 2 = `match_a_evt`, 3 = `match_b_evt`.
- R2: With `gate_pol` = 1 the gate is active while the selected source is high. With `gate_pol` = 0 it is active while the source is low.
- R3: With `gate_en` = 0 the counter advances by one on every clock and `gate_enable_o` is 1. With `gate_en` = 1 it advances only while the shaped gate is active.
- R4: `gate_val_o` shows the shaped gate level (after polarity and toggle) even when `gate_en` = 0.
- R5: In plain gated mode the counter advances exactly once for each clock cycle during which the polarity-adjusted source is active.
- R6: With `toggle_en` = 1 the shaped gate flips on every rising edge of the polarity-adjusted source. The counter therefore advances once per cycle over one full source period, from one rising edge to the next.
- R7: With `toggle_en` = 0 the toggle flip-flop is cleared and held clear. Clearing `toggle_en` while the toggled gate is high stops counting.
- R8: With `spm_en` = 1, a one-cycle pulse on `go_set` raises `go_done_o`. Counting then begins at the next rising edge of the shaped gate. A gate that is already high when the arm arrives is not counted.
- R9: In single-pulse mode, `go_done_o` clears on the trailing edge of the captured gate window. Later gate windows do not advance the counter until the block is armed again.
- R10: With `toggle_en` and `spm_en` both set, one arm captures exactly one full source period, and the periods that follow are ignored.
- R11: Clearing `spm_en` forces `go_done_o` to 0. `go_set` has no effect while `spm_en` = 0.
- R12: A one-cycle `ovf8_evt` pulse on the selected source advances the counter by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_pin | input | 1 | External gate pin, resynchronized internally |
| ovf8_evt | input | 1 | One-cycle pulse when the 8-bit timer wraps from 0xFF to 0x00 |
| match_a_evt | input | 1 | First period-match event |
| match_b_evt | input | 1 | Second period-match event |
| src_sel | input | 2 | Gate source select |
| gate_pol | input | 1 | 1 = active high, 0 = active low |
| gate_en | input | 1 | Master gate enable |
| toggle_en | input | 1 | Toggle (full-period) mode enable |
| spm_en | input | 1 | Single-pulse mode enable |
| go_set | input | 1 | One-cycle arm request for single-pulse mode |
| gate_enable_o | output | 1 | Registered count enable fed to the counter |
| go_done_o | output | 1 | Armed / busy flag of single-pulse mode |
| gate_val_o | output | 1 | Registered shaped gate level |
| count_o | output | 16 | Counter value |

## Verification
The hardest situation to reach from the ports is an arm that lands while the shaped gate is already high. The block must skip that window and wait for a fresh rising edge. The stimulus raises the pin, lets it settle through the synchronizer, pulses `go_set`, and checks that the counter holds. It then drops the pin and raises it again for a known number of cycles. The chained toggle and single-pulse case needs a similar setup: a train of four evenly spaced match pulses is sent after one arm, and only the first period may be counted.

// File: rtl/tgu_pkg.sv
package tgu_pkg;
  typedef enum logic [1:0] {
    SRC_PIN     = 2'd0,
    SRC_OVF8    = 2'd1,
    SRC_MATCH_A = 2'd2,
    SRC_MATCH_B = 2'd3
  } gate_src_e;
endpackage

// File: rtl/tgu_source.sv
module tgu_source #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gate_pin,
  input  logic       ovf8_evt,
  input  logic       match_a_evt,
  input  logic       match_b_evt,
  input  logic [1:0] src_sel,
  input  logic       gate_pol,
  output logic       pol_sig
);
  import tgu_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   raw_src;
  gate_src_e              sel_e;

  // pin resynchronizer chain
  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= gate_pin;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) sync_q[i] <= 1'b0;
          else     sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  assign sel_e = gate_src_e'(src_sel);

  always_comb begin
    unique case (sel_e)
      SRC_PIN:     raw_src = sync_q[SYNC_STAGES-1];
      SRC_OVF8:    raw_src = ovf8_evt;
      SRC_MATCH_A: raw_src = match_a_evt;
      default:     raw_src = match_b_evt;
    endcase
  end

  assign pol_sig = gate_pol ? raw_src : ~raw_src;
endmodule

// File: rtl/tgu_shape.sv
module tgu_shape (
  input  logic clk,
  input  logic rst,
  input  logic pol_sig,
  input  logic toggle_en,
  input  logic spm_en,
  input  logic go_set,
  output logic shaped,
  output logic gate_lvl,
  output logic go_done
);
  logic pol_d, tog_q, shaped_d, run_q, go_q;
  logic src_rise, g_rise, g_fall, start;

  assign src_rise = pol_sig & ~pol_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_d    <= 1'b0;
      tog_q    <= 1'b0;
      shaped_d <= 1'b0;
    end else begin
      pol_d    <= pol_sig;
      shaped_d <= shaped;
      if (!toggle_en)    tog_q <= 1'b0;
      else if (src_rise) tog_q <= ~tog_q;
    end
  end

  assign shaped = toggle_en ? tog_q : pol_sig;
  assign g_rise = shaped & ~shaped_d;
  assign g_fall = ~shaped & shaped_d;
  assign start  = go_q & ~run_q & g_rise;

  always_ff @(posedge clk) begin
    if (rst || !spm_en) begin
      run_q <= 1'b0;
      go_q  <= 1'b0;
    end else if (run_q && g_fall) begin
      run_q <= 1'b0;
      go_q  <= 1'b0;
    end else begin
      if (start)  run_q <= 1'b1;
      if (go_set) go_q  <= 1'b1;
    end
  end

  assign gate_lvl = spm_en ? (shaped & (run_q | start)) : shaped;
  assign go_done  = go_q;

  // R7: flip-flop held clear while toggle mode is off
  a_r7_toggle_clear: assert property (@(posedge clk) disable iff (rst)
    !toggle_en |=> !tog_q);
  // R11: disabling single-pulse mode drops the arm flag
  a_r11_go_needs_spm: assert property (@(posedge clk) disable iff (rst)
    !spm_en |=> !go_q);
  // R9: the arm flag only drops on a trailing edge of a running window or a mode clear
  a_r9_go_fall_cause: assert property (@(posedge clk) disable iff (rst)
    (go_q && spm_en && !(run_q && g_fall)) |=> go_q);
endmodule

// File: rtl/tgu_counter.sv
module tgu_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)     cnt_q <= '0;
    else if (en) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt = cnt_q;

  // R5: no advance without an enable
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt_q == $past(cnt_q));
  // R5: one step per enabled cycle
  a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
    en |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/tmr_gate_unit.sv
module tmr_gate_unit #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_pin,
  input  logic             ovf8_evt,
  input  logic             match_a_evt,
  input  logic             match_b_evt,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             gate_pol,
  input  logic             gate_en,
  input  logic             toggle_en,
  input  logic             spm_en,
  input  logic             go_set,
  output logic             gate_enable_o,
  output logic             go_done_o,
  output logic             gate_val_o,
  output logic [CNT_W-1:0] count_o
);
  logic pol_sig, shaped, gate_lvl, go_done;
  logic en_q, val_q;

  tgu_source #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk(clk), .rst(rst), .gate_pin(gate_pin), .ovf8_evt(ovf8_evt),
    .match_a_evt(match_a_evt), .match_b_evt(match_b_evt),
    .src_sel(src_sel), .gate_pol(gate_pol), .pol_sig(pol_sig)
  );

  tgu_shape u_shape (
    .clk(clk), .rst(rst), .pol_sig(pol_sig), .toggle_en(toggle_en),
    .spm_en(spm_en), .go_set(go_set), .shaped(shaped),
    .gate_lvl(gate_lvl), .go_done(go_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      val_q <= 1'b0;
    end else begin
      en_q  <= gate_en ? gate_lvl : 1'b1;
      val_q <= shaped;
    end
  end

  tgu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en_q), .cnt(count_o)
  );

  assign gate_enable_o = en_q;
  assign gate_val_o    = val_q;
  assign go_done_o     = go_done;

  // R3: master enable clear means free counting
  a_r3_free_run: assert property (@(posedge clk) disable iff (rst)
    !gate_en |=> gate_enable_o);
  // R8: an unarmed single-pulse mode never enables the counter
  a_r8_no_arm_no_count: assert property (@(posedge clk) disable iff (rst)
    (gate_en && spm_en && !go_done_o) |=> !gate_enable_o);
endmodule

// File: tb/tmr_gate_unit_test.sv
`timescale 1ns/1ps
module tmr_gate_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gate_pin = 0, ovf8_evt = 0, match_a_evt = 0, match_b_evt = 0;
  logic [1:0] src_sel = 0;
  logic gate_pol = 1, gate_en = 0, toggle_en = 0, spm_en = 0, go_set = 0;
  logic gate_enable_o, go_done_o, gate_val_o;
  logic [15:0] count_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] c0;

  always #2 clk = ~clk;

  tmr_gate_unit uut (
    .clk(clk), .rst(rst), .gate_pin(gate_pin), .ovf8_evt(ovf8_evt),
    .match_a_evt(match_a_evt), .match_b_evt(match_b_evt), .src_sel(src_sel),
    .gate_pol(gate_pol), .gate_en(gate_en), .toggle_en(toggle_en),
    .spm_en(spm_en), .go_set(go_set), .gate_enable_o(gate_enable_o),
    .go_done_o(go_done_o), .gate_val_o(gate_val_o), .count_o(count_o)
  );

  // {sel[1:0], pol, pin, ovf, match_a, match_b, expected gate level}
  localparam logic [7:0] VEC [12] = '{
    8'b00_1_1000_1, 8'b00_1_0111_0, 8'b00_0_0111_1,
    8'b01_1_0100_1, 8'b01_1_1011_0, 8'b01_0_1011_1,
    8'b10_1_0010_1, 8'b10_1_1101_0, 8'b10_0_0010_0,
    8'b11_1_0001_1, 8'b11_1_1110_0, 8'b11_0_1110_1
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_pin(input int n);
    gate_pin = 1; tick(n); gate_pin = 0;
  endtask

  task automatic arm();
    go_set = 1; tick(1); go_set = 0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 0;
    chk(count_o == 0, "reset count", count_o, 0);
    chk(go_done_o == 0, "reset go_done", go_done_o, 0);
    chk(gate_val_o == 0, "reset gate_val", gate_val_o, 0);

    // R3: free counting with the master enable clear
    tick(2); c0 = count_o; tick(10);
    chk(count_o - c0 == 10, "R3 free count", count_o - c0, 10);

    // R1 R2: source and polarity table
    gate_en = 1;
    for (int i = 0; i < 12; i++) begin
      src_sel = VEC[i][7:6]; gate_pol = VEC[i][5]; gate_pin = VEC[i][4];
      ovf8_evt = VEC[i][3]; match_a_evt = VEC[i][2]; match_b_evt = VEC[i][1];
      tick(5);
      chk(gate_val_o == VEC[i][0], $sformatf("R1 R2 vector %0d gate_val", i), gate_val_o, VEC[i][0]);
      chk(gate_enable_o == VEC[i][0], $sformatf("R1 R2 vector %0d enable", i), gate_enable_o, VEC[i][0]);
    end
    gate_pin = 0; ovf8_evt = 0; match_a_evt = 0; match_b_evt = 0;
    src_sel = 0; gate_pol = 1; tick(6);

    // R5: pin high for 20 cycles
    c0 = count_o; pulse_pin(20); tick(8);
    chk(count_o - c0 == 20, "R5 pin high window", count_o - c0, 20);

    // R2: active-low pin window of 15 cycles
    gate_pin = 1; gate_pol = 0; tick(8);
    c0 = count_o; gate_pin = 0; tick(15); gate_pin = 1; tick(8);
    chk(count_o - c0 == 15, "R2 active-low window", count_o - c0, 15);
    gate_pin = 0; gate_pol = 1; tick(6);

    // R12: five single overflow pulses
    src_sel = 2'd1; tick(3); c0 = count_o;
    for (int k = 0; k < 5; k++) begin
      ovf8_evt = 1; tick(1); ovf8_evt = 0; tick(3);
    end
    tick(4);
    chk(count_o - c0 == 5, "R12 overflow pulses", count_o - c0, 5);

    // R6: toggle mode counts one full period of match_a
    src_sel = 2'd2; toggle_en = 1; tick(3); c0 = count_o;
    match_a_evt = 1; tick(1); match_a_evt = 0; tick(9);
    match_a_evt = 1; tick(1); match_a_evt = 0; tick(6);
    chk(count_o - c0 == 10, "R6 full period", count_o - c0, 10);

    // R7: clearing toggle mode stops a running toggled gate
    match_a_evt = 1; tick(1); match_a_evt = 0; tick(3);
    chk(gate_val_o == 1, "R7 toggled gate high", gate_val_o, 1);
    toggle_en = 0; tick(3);
    chk(gate_val_o == 0, "R7 toggle cleared", gate_val_o, 0);
    c0 = count_o; tick(5);
    chk(count_o - c0 == 0, "R7 counting stopped", count_o - c0, 0);

    // R8 R9: single-pulse capture on the pin
    src_sel = 2'd0; spm_en = 1; tick(2); arm(); tick(2);
    chk(go_done_o == 1, "R8 armed", go_done_o, 1);
    c0 = count_o; pulse_pin(12); tick(8);
    chk(count_o - c0 == 12, "R8 captured window", count_o - c0, 12);
    chk(go_done_o == 0, "R9 self clear", go_done_o, 0);
    c0 = count_o; pulse_pin(8); tick(8);
    chk(count_o - c0 == 0, "R9 later window ignored", count_o - c0, 0);

    // R8: arm while the gate is already high
    gate_pin = 1; tick(6); arm(); c0 = count_o; tick(10);
    chk(count_o - c0 == 0, "R8 high-at-arm skipped", count_o - c0, 0);
    gate_pin = 0; tick(4); pulse_pin(6); tick(8);
    chk(count_o - c0 == 6, "R8 next window counted", count_o - c0, 6);

    // R11: clearing single-pulse mode drops the arm; go_set ignored when off
    arm(); tick(1);
    chk(go_done_o == 1, "R11 armed", go_done_o, 1);
    spm_en = 0; tick(2);
    chk(go_done_o == 0, "R11 forced clear", go_done_o, 0);
    arm(); tick(1);
    chk(go_done_o == 0, "R11 go_set ignored", go_done_o, 0);

    // R10: toggle and single-pulse chained on match_b
    src_sel = 2'd3; spm_en = 1; toggle_en = 1; tick(3); arm(); tick(3);
    c0 = count_o;
    for (int k = 0; k < 4; k++) begin
      match_b_evt = 1; tick(1); match_b_evt = 0; tick(6);
    end
    tick(4);
    chk(count_o - c0 == 7, "R10 one period", count_o - c0, 7);
    chk(go_done_o == 0, "R10 done", go_done_o, 0);

    // R4: status follows the gate with the master enable clear
    spm_en = 0; toggle_en = 0; src_sel = 2'd0; gate_en = 0; gate_pin = 1; tick(5);
    chk(gate_val_o == 1, "R4 status high", gate_val_o, 1);
    c0 = count_o; gate_pin = 0; tick(5);
    chk(gate_val_o == 0, "R4 status low", gate_val_o, 0);
    chk(count_o - c0 == 5, "R3 R4 still free counting", count_o - c0, 5);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule